// File: doc/BRIEF.md
# TDC Hit Timestamp Word Assembler

This block turns hit reports from a multi-channel time-to-digital converter into a stream of 32-bit time data words. It runs a free coarse counter that steps once per system clock, and an epoch counter that counts the coarse counter's wraps. The two counters together give an absolute time reference. When a hit arrives it carries a channel number, a 10-bit fine time and an edge flag. The block stamps the hit with the present coarse and epoch values, parks it in a one-entry pending slot and then emits a hit word.

The receiver only gets the coarse value in each hit word. It therefore needs to know which epoch that coarse value belongs to. Before any hit whose epoch differs from the last epoch word put on the stream, the block inserts an epoch word. An epoch word is also inserted before the first hit after reset.

The output is one registered word with a valid/ready handshake. While it is stalled, one more hit can wait in the pending slot. A hit that arrives when neither place can take it is discarded, and a one-cycle drop pulse reports the loss.

Top module: `tdc_word_assembler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `outValid` and `hitDropped` are 0. The coarse counter reads 0 at the first clock edge after reset is released.
- R2: The coarse counter increments by one on every clock and wraps to 0 after 2^COARSE_W counts. The default is 11 bits, which is 2048 counts. A hit word carries, zero-extended in bits 10..0, the coarse value present at the clock edge that accepts the hit.
- R3: The epoch counter increments, modulo 2^EPOCH_W, at exactly the edges where the coarse counter wraps to 0.
- R4: A hit word has the following layout:
  - bit 31 = 1.
  - bit 30 = 0.
  - bit 29 = the `hitApprox` flag.
  - bits 28..22 = channel.
  - bits 21..12 = fine time.
  - bit 11 = edge flag, 1 for rising and 0 for falling.
- R5: An epoch word has bits 31..29 = 3'b011 and bit 28 = 0. Bits 27..0 hold the hit's epoch value, zero-extended.
- R6: An epoch word comes immediately before a hit word when that hit's epoch differs from the epoch in the last epoch word sent. It also comes before the first hit after reset. In every other case no epoch word is inserted. Words leave in the order their hits were accepted.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` and `outWord` stay unchanged at the next edge.
- R8: A hit is discarded when it is offered while the pending slot is occupied and that slot does not hand its hit word to the output at the same edge. `hitDropped` is then 1 in the following cycle. The held output word and the pending hit are not altered, and the discarded hit never appears on the stream.
- R9: With `outReady` held at 1 and no epoch change, a hit can be accepted on every clock. Each hit word is valid on the output one cycle after the edge that accepted the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the coarse time step |
| rstN | input | 1 | Synchronous reset, active low |
| hitValid | input | 1 | A hit is offered this cycle |
| hitChan | input | 7 | Channel number of the hit |
| hitFine | input | 10 | Fine time of the hit |
| hitRising | input | 1 | 1 for a rising edge, 0 for a falling edge |
| hitApprox | input | 1 | Marks the time value as corrected/approximate |
| outReady | input | 1 | Downstream accepts the word this cycle |
| outValid | output | 1 | `outWord` holds a word |
| outWord | output | 32 | Hit word or epoch word |
| hitDropped | output | 1 | Pulses one cycle after a discarded hit |

## Verification
A hit accepted at edge E normally gives its hit word on the output right after edge E+1. If an epoch word must come first, the epoch word appears after E+1 and the hit word after E+2, and only once the epoch word has been taken. The bench does not predict the exact latency under random backpressure. It keeps a queue of the words it expects, computed from its own cycle count since reset, and compares every transfer against the head of that queue at the falling edge. Hold, drop and back-to-back latency are checked in directed cycles. In those cycles the drop pulse is sampled one cycle after the offending edge, and the burst's last word is sampled one cycle after its capture edge.

// File: rtl/tdcw_pkg.sv
package tdcw_pkg;

  localparam int WORD_W         = 32;
  localparam int CHAN_W         = 7;
  localparam int FINE_W         = 10;
  localparam int COARSE_FIELD_W = 11;
  localparam int EPOCH_FIELD_W  = 28;

  localparam logic [2:0] EPOCH_TAG = 3'b011;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic loadEpoch;  // put the pending hit's epoch word on the output
    logic loadHit;    // put the pending hit's hit word on the output, free slot
    logic capture;    // take the offered hit into the pending slot
    logic drop;       // offered hit is lost
  } tdcwStrobes_t;

  // A stamped hit waiting for its word slot.
  typedef struct packed {
    logic [CHAN_W-1:0]         chan;
    logic [FINE_W-1:0]         fine;
    logic                      rising;
    logic                      approx;
    logic [COARSE_FIELD_W-1:0] coarse;
    logic [EPOCH_FIELD_W-1:0]  epoch;
  } tdcwHit_t;

  function automatic logic [WORD_W-1:0] packHitWord(input tdcwHit_t h);
    return {1'b1, 1'b0, h.approx, h.chan, h.fine, h.rising, h.coarse};
  endfunction

  function automatic logic [WORD_W-1:0] packEpochWord(input logic [EPOCH_FIELD_W-1:0] e);
    return {EPOCH_TAG, 1'b0, e};
  endfunction

endpackage

// File: rtl/tdcw_timebase.sv
module tdcw_timebase #(
  parameter int COARSE_W = 11,
  parameter int EPOCH_W  = 28
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [COARSE_W-1:0] coarseNow,
  output logic [EPOCH_W-1:0]  epochNow
);

  localparam logic [COARSE_W-1:0] COARSE_LAST = '1;

  logic coarseWrap;
  assign coarseWrap = (coarseNow == COARSE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coarseNow <= '0;
      epochNow  <= '0;
    end else begin
      coarseNow <= coarseNow + COARSE_W'(1);
      if (coarseWrap) epochNow <= epochNow + EPOCH_W'(1);
    end
  end

endmodule

// File: rtl/tdcw_control.sv
module tdcw_control
  import tdcw_pkg::*;
(
  input  logic         hitValid,
  input  logic         pendValid,
  input  logic         epochMatch,
  input  logic         outValid,
  input  logic         outReady,
  output tdcwStrobes_t strobes
);

  logic outFree;

  always_comb begin
    outFree           = !outValid || outReady;
    strobes.loadEpoch = pendValid && outFree && !epochMatch;
    strobes.loadHit   = pendValid && outFree && epochMatch;
    // The slot can refill at the same edge it hands its hit word on.
    strobes.capture   = hitValid && (!pendValid || strobes.loadHit);
    strobes.drop      = hitValid && !strobes.capture;
  end

endmodule

// File: rtl/tdcw_datapath.sv
module tdcw_datapath
  import tdcw_pkg::*;
#(
  parameter int COARSE_W = 11,
  parameter int EPOCH_W  = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  tdcwStrobes_t        strobes,
  input  logic [COARSE_W-1:0] coarseNow,
  input  logic [EPOCH_W-1:0]  epochNow,
  input  logic [CHAN_W-1:0]   hitChan,
  input  logic [FINE_W-1:0]   hitFine,
  input  logic                hitRising,
  input  logic                hitApprox,
  input  logic                outReady,
  output logic                pendValid,
  output logic                epochMatch,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord,
  output logic                hitDropped
);

  tdcwHit_t                 pendHit;
  tdcwHit_t                 newHit;
  logic                     lastValid;
  logic [EPOCH_FIELD_W-1:0] lastEpoch;

  always_comb begin
    newHit.chan   = hitChan;
    newHit.fine   = hitFine;
    newHit.rising = hitRising;
    newHit.approx = hitApprox;
    newHit.coarse = COARSE_FIELD_W'(coarseNow);
    newHit.epoch  = EPOCH_FIELD_W'(epochNow);
  end

  assign epochMatch = lastValid && (lastEpoch == pendHit.epoch);

  // Pending slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendHit   <= '0;
    end else if (strobes.capture) begin
      pendValid <= 1'b1;
      pendHit   <= newHit;
    end else if (strobes.loadHit) begin
      pendValid <= 1'b0;
    end
  end

  // Last epoch put on the stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastValid <= 1'b0;
      lastEpoch <= '0;
    end else if (strobes.loadEpoch) begin
      lastValid <= 1'b1;
      lastEpoch <= pendHit.epoch;
    end
  end

  // Output stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else if (strobes.loadEpoch) begin
      outValid <= 1'b1;
      outWord  <= packEpochWord(pendHit.epoch);
    end else if (strobes.loadHit) begin
      outValid <= 1'b1;
      outWord  <= packHitWord(pendHit);
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hitDropped <= 1'b0;
    else       hitDropped <= strobes.drop;
  end

endmodule

// File: rtl/tdc_word_assembler.sv
module tdc_word_assembler
  import tdcw_pkg::*;
#(
  parameter int COARSE_W = 11,
  parameter int EPOCH_W  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hitValid,
  input  logic [6:0]        hitChan,
  input  logic [9:0]        hitFine,
  input  logic              hitRising,
  input  logic              hitApprox,
  input  logic              outReady,
  output logic              outValid,
  output logic [31:0]       outWord,
  output logic              hitDropped
);

  logic [COARSE_W-1:0] coarseNow;
  logic [EPOCH_W-1:0]  epochNow;
  logic                pendValid;
  logic                epochMatch;
  tdcwStrobes_t        strobes;

  tdcw_timebase #(.COARSE_W(COARSE_W), .EPOCH_W(EPOCH_W)) u_timebase (
    .clk       (clk),
    .rstN      (rstN),
    .coarseNow (coarseNow),
    .epochNow  (epochNow)
  );

  tdcw_control u_control (
    .hitValid   (hitValid),
    .pendValid  (pendValid),
    .epochMatch (epochMatch),
    .outValid   (outValid),
    .outReady   (outReady),
    .strobes    (strobes)
  );

  tdcw_datapath #(.COARSE_W(COARSE_W), .EPOCH_W(EPOCH_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .coarseNow  (coarseNow),
    .epochNow   (epochNow),
    .hitChan    (hitChan),
    .hitFine    (hitFine),
    .hitRising  (hitRising),
    .hitApprox  (hitApprox),
    .outReady   (outReady),
    .pendValid  (pendValid),
    .epochMatch (epochMatch),
    .outValid   (outValid),
    .outWord    (outWord),
    .hitDropped (hitDropped)
  );

endmodule

// File: rtl/tdcw_checker.sv
module tdcw_checker #(
  parameter int COARSE_W = 11,
  parameter int EPOCH_W  = 28
) (
  input logic                clk,
  input logic                rstN,
  input logic                hitValid,
  input logic                outReady,
  input logic                outValid,
  input logic [31:0]         outWord,
  input logic                hitDropped,
  input logic [COARSE_W-1:0] coarseNow,
  input logic [EPOCH_W-1:0]  epochNow
);

  localparam logic [COARSE_W-1:0] COARSE_LAST = '1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!outValid && !hitDropped));

  a_r2_coarse_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (coarseNow == $past(coarseNow) + COARSE_W'(1)));

  a_r3_epoch_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (epochNow != $past(epochNow))) |-> ($past(coarseNow) == COARSE_LAST));

  a_r4_r5_word_kind: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outWord[31] && !outWord[30]) || (outWord[31:28] == 4'b0110)));

  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));

  a_r8_drop_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    hitDropped |-> $past(hitValid));

  a_r8_drop_leaves_word: assert property (@(posedge clk) disable iff (!rstN)
    hitDropped |-> outValid);

endmodule

bind tdc_word_assembler tdcw_checker #(.COARSE_W(COARSE_W), .EPOCH_W(EPOCH_W)) u_tdcwChecker (
  .clk        (clk),
  .rstN       (rstN),
  .hitValid   (hitValid),
  .outReady   (outReady),
  .outValid   (outValid),
  .outWord    (outWord),
  .hitDropped (hitDropped),
  .coarseNow  (coarseNow),
  .epochNow   (epochNow)
);

// File: tb/test_tdc_word_assembler.sv
module test_tdc_word_assembler;

  localparam int CW = 4;
  localparam int EW = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hitValid = 1'b0;
  logic [6:0]  hitChan = '0;
  logic [9:0]  hitFine = '0;
  logic        hitRising = 1'b0;
  logic        hitApprox = 1'b0;
  logic        outReady = 1'b0;
  logic        outValid;
  logic [31:0] outWord;
  logic        hitDropped;

  int nChecks = 0;
  int nFails  = 0;
  int readyMode = 1;  // 0 random, 1 high, 2 low
  bit expectDrop = 1'b0;
  bit done = 1'b0;

  longint unsigned tot;
  logic [31:0] expQ[$];
  bit          lastSentOk = 1'b0;
  logic [EW-1:0] lastSentEp = '0;

  logic        prevValid = 1'b0;
  logic        prevReady = 1'b0;
  logic [31:0] prevWord = '0;

  tdc_word_assembler #(.COARSE_W(CW), .EPOCH_W(EW)) i_tdc_word_assembler (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitChan(hitChan),
    .hitFine(hitFine), .hitRising(hitRising), .hitApprox(hitApprox),
    .outReady(outReady), .outValid(outValid), .outWord(outWord),
    .hitDropped(hitDropped)
  );

  always #4 clk = ~clk;

  // Bench time reference: counts clocks since reset release (R1, R2)
  always @(posedge clk) begin
    if (!rstN) tot <= 0;
    else       tot <= tot + 1;
  end

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (readyMode == 1)      outReady = 1'b1;
      else if (readyMode == 2) outReady = 1'b0;
      else                     outReady = 1'($urandom_range(0, 1));
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishTest();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Stream monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevValid && !prevReady)
        check(outValid && (outWord == prevWord), "R7 hold", outWord, prevWord);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected word", outWord, 32'h0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(outWord == e, "R2 R3 R4 R5 R6 word", outWord, e);
        end
      end
      if (hitDropped && !expectDrop)
        check(1'b0, "R8 unexpected drop", 32'(hitDropped), 32'h0);
      prevValid = outValid;
      prevReady = outReady;
      prevWord  = outWord;
    end
  end

  // Drive a hit for the next edge and record its expected words (R2 R4 R5 R6)
  task automatic driveHit(input logic [6:0] ch, input logic [9:0] fn, input bit rise,
                          input bit apx, input bit accept);
    logic [EW-1:0] ep;
    logic [CW-1:0] co;
    hitValid  = 1'b1;
    hitChan   = ch;
    hitFine   = fn;
    hitRising = rise;
    hitApprox = apx;
    co = CW'(tot);
    ep = EW'(tot >> CW);
    if (accept) begin
      if (!lastSentOk || ep != lastSentEp) begin
        expQ.push_back({3'b011, 1'b0, 28'(ep)});
        lastSentOk = 1'b1;
        lastSentEp = ep;
      end
      expQ.push_back({1'b1, 1'b0, apx, ch, fn, rise, 11'(co)});
    end
  endtask

  task automatic oneHit(input logic [6:0] ch, input logic [9:0] fn, input bit rise, input bit apx);
    @(posedge clk); #1;
    driveHit(ch, fn, rise, apx, 1'b1);
    @(posedge clk); #1;
    hitValid = 1'b0;
  endtask

  task automatic waitDrain();
    int n = 0;
    @(posedge clk); #3;
    while ((expQ.size() != 0 || outValid) && n < 300) begin
      @(posedge clk); #3;
      n++;
    end
    check(n < 300, "R6 R7 stream drains", 32'(expQ.size()), 32'h0);
  endtask

  task automatic waitCoarse(input int v);
    @(posedge clk); #1;
    while (int'(tot % (1 << CW)) != v) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    readyMode = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!outValid && !hitDropped, "R1 reset outputs", {outValid, hitDropped}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !hitDropped, "R1 after release", {outValid, hitDropped}, 32'h0);

    // R8: stall output, hit A fills slot, hit B is discarded
    readyMode = 2;
    repeat (2) @(posedge clk);
    @(posedge clk); #1;
    driveHit(7'd5, 10'd77, 1'b1, 1'b0, 1'b1);
    @(posedge clk); #1;              // A captured
    hitValid = 1'b0;
    @(posedge clk); #1;              // epoch word loaded
    expectDrop = 1'b1;
    driveHit(7'd9, 10'd300, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;              // B offered while slot full
    hitValid = 1'b0;
    @(negedge clk);
    check(hitDropped == 1'b1, "R8 drop pulse", 32'(hitDropped), 32'h1);
    check(outValid && outWord == expQ[0], "R8 held word kept", outWord, expQ[0]);
    @(posedge clk); #1;
    expectDrop = 1'b0;
    @(negedge clk);
    check(hitDropped == 1'b0, "R8 pulse one cycle", 32'(hitDropped), 32'h0);
    readyMode = 1;
    waitDrain();

    // R9: back-to-back within one epoch
    waitCoarse(1);
    driveHit(7'd1, 10'd1, 1'b1, 1'b0, 1'b1);
    @(posedge clk); #1;
    hitValid = 1'b0;
    waitDrain();
    waitCoarse(8);
    for (int k = 0; k < 6; k++) begin
      driveHit(7'(20 + k), 10'(100 * k + 3), k[0], k[1], 1'b1);
      @(posedge clk); #1;
    end
    hitValid = 1'b0;
    begin
      logic [31:0] lastExp;
      lastExp = expQ[expQ.size() - 1];
      @(posedge clk); #3;
      check(outValid && outWord == lastExp, "R9 burst latency", outWord, lastExp);
    end
    waitDrain();

    // R2 R3: hits at the last coarse value and right after the wrap
    waitCoarse(15);
    driveHit(7'd127, 10'd1023, 1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    driveHit(7'd0, 10'd0, 1'b0, 1'b0, 1'b0);
    hitValid = 1'b0;
    waitDrain();
    waitCoarse(0);
    driveHit(7'd0, 10'd0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    hitValid = 1'b0;
    waitDrain();

    // Sweep all channels under random backpressure (R2..R7)
    readyMode = 0;
    for (int ch = 0; ch < 128; ch++) begin
      repeat (ch % 5) @(posedge clk);
      oneHit(7'(ch), 10'((ch * 37 + 5) % 1024), ch[0], ch[1]);
      waitDrain();
    end
    readyMode = 1;
    waitDrain();
    check(expQ.size() == 0, "R6 all words seen", 32'(expQ.size()), 32'h0);
    finishTest();
  end

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired at %0t", $time);
    finishTest();
  end

endmodule